// File: doc/BRIEF.md
# Fractional Clock Divider with Integer and 1/32 Fraction

This block divides its input clock by a programmable ratio made of an integer part and a fractional part. The integer part is a 24-bit field giving a base ratio of field+1. The fractional part is a 5-bit field in 1/32 steps. At every period boundary the fraction is added into a 5-bit accumulator. When that addition carries out, the next period lasts one input cycle longer. The mean ratio therefore lands on the programmed value, at the cost of one input cycle of jitter.

Two outputs are produced. The first is a one-cycle enable pulse at the end of each divided period. The second is a divided clock, low for the first half of each period and high for the rest. Software programs the ratio through a 32-bit control word. Separate start and stop commands run and halt the divider, and a read-only status bit shows whether it is running. A low-power-exit strobe restarts the counting from zero but keeps the settings and the running state.

Top module: `frac_clk_div`

## Requirements
- R1: The control word reads back as {integer[31:8], fraction[7:3], 2'b00, running[0]}. A write stores bits 31:8 as the integer field and bits 7:3 as the fraction field. After reset the word reads 0.
- R2: Bit 0 and bits 2:1 of a written word have no effect. The running bit changes only through the commands.
- R3: When a start command arrives while the divider is stopped, the running bit sets on the next edge. The first pulse then comes N = integer+1 cycles after the cycle in which the command was applied.
- R4: A stop command clears the running bit on the next edge. While the divider is stopped, the pulse stays low and the divided clock is low from the second cycle on. When stop and start arrive together, stop wins.
- R5: The pulse is high for exactly one cycle per period. With integer 0 and fraction 0, it is high in every cycle.
- R6: At each boundary the fraction is added to a 5-bit accumulator, which starts at 0 on start. A carry makes the following period one cycle longer, so each period lasts N or N+1 cycles. Over 32 periods after the first, the total is 32·N plus the fraction.
- R7: A write to the ratio fields while running takes effect from the next period boundary. The period in progress keeps its length.
- R8: For each period of length L, the divided clock is low for floor(L/2) cycles and high for ceil(L/2) cycles, lagging the period counter by one cycle.
- R9: A low-power-exit strobe while running sets the counters and the accumulator to zero. A new period of N cycles starts with the next cycle, and the running bit and the fields are kept.
- R10: A start command while the divider is already running has no effect on the period in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| cmd_start | input | 1 | Start command, one-cycle strobe |
| cmd_stop | input | 1 | Stop command, one-cycle strobe |
| lp_exit | input | 1 | Low-power-exit strobe that restarts the counters |
| reg_rdata | output | 32 | Control word readback including running bit |
| tick_o | output | 1 | One-cycle pulse at the end of each divided period |
| clk_div_o | output | 1 | Divided clock output |

## Verification
The readback and the running bit follow a write or a command one edge later. The end-of-period pulse is combinational from registered state, so the first pulse after a start, restart or low-power exit shows N sampling points after the stimulus. The divided clock comes from a register and lags the period phase by one more cycle. The bench samples every output on the falling edge. A reference model advances on the rising edge, so each of these comparisons lines up with the cycle in which the value is due. Directed checks count falling edges between pulses to measure period lengths.

// File: rtl/fcd_pkg.sv
// Package: shared constants and action encoding for the fractional divider.
// Assumes the control word layout is fixed: status bit 0, reserved bits 2:1,
// fraction from bit 3 upward, integer directly above the fraction.
package fcd_pkg;

    localparam int RUN_BIT  = 0;
    localparam int FRAC_LSB = 3;

    // Counter-level action decoded from the commands of one cycle
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_RUN    = 2'd1,
        ACT_HALT   = 2'd2,
        ACT_REINIT = 2'd3
    } fcd_act_e;

endpackage

// File: rtl/fcd_regs.sv
// Module: control word storage and command decode.
// Holds the integer and fraction fields and the running status, and decides
// which counter action applies this cycle (halt > run > reinit).
// Assumes commands are single-cycle strobes.
module fcd_regs #(
    parameter int INT_W  = 24,
    parameter int FRAC_W = 5,
    localparam int CTL_W = fcd_pkg::FRAC_LSB + FRAC_W + INT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CTL_W-1:0]   wr_data,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               wake_i,
    output logic [INT_W-1:0]   int_sh,
    output logic [FRAC_W-1:0]  frac_sh,
    output logic               running,
    output fcd_pkg::fcd_act_e  act,
    output logic [CTL_W-1:0]   rd_data
);
    import fcd_pkg::*;

    localparam int INT_LSB = FRAC_LSB + FRAC_W;

    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic              run_q;
    logic              wr_low_unused;

    // Low bits of a write carry no setting
    assign wr_low_unused = ^wr_data[FRAC_LSB-1:0];

    // Store the ratio fields on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q  <= '0;
            frac_q <= '0;
        end else if (wr_en) begin
            int_q  <= wr_data[INT_LSB +: INT_W];
            frac_q <= wr_data[FRAC_LSB +: FRAC_W];
        end
    end

    // Running status: stop has priority over start
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 1'b0;
        else if (stop_i)  run_q <= 1'b0;
        else if (start_i) run_q <= 1'b1;
    end

    // Decode the counter action for this cycle
    always_comb begin
        if (stop_i)                 act = ACT_HALT;
        else if (start_i && !run_q) act = ACT_RUN;
        else if (wake_i)            act = ACT_REINIT;
        else                        act = ACT_NONE;
    end

    // Assemble the readback word
    always_comb begin
        rd_data                      = '0;
        rd_data[INT_LSB +: INT_W]    = int_q;
        rd_data[FRAC_LSB +: FRAC_W]  = frac_q;
        rd_data[RUN_BIT]             = run_q;
    end

    assign int_sh  = int_q;
    assign frac_sh = frac_q;
    assign running = run_q;

endmodule

// File: rtl/fcd_core.sv
// Module: period counter with fractional accumulator.
// Counts each period from 0 to its limit (integer + stretch). At the end of a
// period it loads the next integer setting and adds the fraction into the
// accumulator; a carry stretches the next period by one cycle.
// Assumes act is already prioritised by fcd_regs.
module fcd_core #(
    parameter int INT_W  = 24,
    parameter int FRAC_W = 5,
    localparam int CNT_W = INT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  fcd_pkg::fcd_act_e  act,
    input  logic               running,
    input  logic [INT_W-1:0]   int_sh,
    input  logic [FRAC_W-1:0]  frac_sh,
    output logic               tick,
    output logic [CNT_W-1:0]   cnt,
    output logic [CNT_W-1:0]   half
);
    import fcd_pkg::*;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  limit;
    logic [INT_W-1:0]  int_act_q;
    logic [FRAC_W-1:0] acc_q;
    logic              str_q;
    logic [FRAC_W:0]   acc_sum;
    logic [CNT_W:0]    len;
    logic              at_end;
    logic              half_lsb_unused;

    // Current period limit including the fractional stretch
    always_comb begin
        limit   = {1'b0, int_act_q} + {{INT_W{1'b0}}, str_q};
        len     = {1'b0, limit} + {{CNT_W{1'b0}}, 1'b1};
        acc_sum = {1'b0, acc_q} + {1'b0, frac_sh};
        at_end  = running && (cnt_q == limit);
    end

    assign half_lsb_unused = len[0];

    // Advance the counter, restart it on any command action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            int_act_q <= '0;
            acc_q     <= '0;
            str_q     <= 1'b0;
        end else if (act != ACT_NONE) begin
            cnt_q     <= '0;
            int_act_q <= int_sh;
            acc_q     <= '0;
            str_q     <= 1'b0;
        end else if (at_end) begin
            cnt_q     <= '0;
            int_act_q <= int_sh;
            acc_q     <= acc_sum[FRAC_W-1:0];
            str_q     <= acc_sum[FRAC_W];
        end else if (running) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = at_end;
    assign cnt  = cnt_q;
    assign half = len[CNT_W:1];

endmodule

// File: rtl/fcd_clkgen.sv
// Module: divided clock former.
// Drives the output low while the period counter is below half the period
// length and high from there on, through one register so the output is free
// of combinational glitches. Assumes half = floor(length/2).
module fcd_clkgen #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] half,
    output logic             clk_div
);

    logic clk_q;

    // Register the phase compare
    always_ff @(posedge clk) begin
        if (!rst_n) clk_q <= 1'b0;
        else        clk_q <= running && (cnt >= half);
    end

    assign clk_div = clk_q;

endmodule

// File: rtl/frac_clk_div.sv
// Module: top of the fractional clock divider.
// Connects the control word storage, the period counter and the divided
// clock former. Assumes one input clock domain and single-cycle strobes.
module frac_clk_div #(
    parameter int INT_W  = 24,
    parameter int FRAC_W = 5,
    localparam int CTL_W = fcd_pkg::FRAC_LSB + FRAC_W + INT_W,
    localparam int CNT_W = INT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [CTL_W-1:0] reg_wdata,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             lp_exit,
    output logic [CTL_W-1:0] reg_rdata,
    output logic             tick_o,
    output logic             clk_div_o
);
    import fcd_pkg::*;

    logic [INT_W-1:0]  int_sh;
    logic [FRAC_W-1:0] frac_sh;
    logic              running;
    fcd_act_e          act;
    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  half_w;

    fcd_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_data (reg_wdata),
        .start_i (cmd_start),
        .stop_i  (cmd_stop),
        .wake_i  (lp_exit),
        .int_sh  (int_sh),
        .frac_sh (frac_sh),
        .running (running),
        .act     (act),
        .rd_data (reg_rdata)
    );

    fcd_core #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .running (running),
        .int_sh  (int_sh),
        .frac_sh (frac_sh),
        .tick    (tick_o),
        .cnt     (cnt_w),
        .half    (half_w)
    );

    fcd_clkgen #(.CNT_W(CNT_W)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .cnt     (cnt_w),
        .half    (half_w),
        .clk_div (clk_div_o)
    );

endmodule

// File: rtl/fcd_chk.sv
// Module: assertion checker bound to frac_clk_div.
// Watches commands, readback and outputs; assumes default bit positions of
// the status bit and the reserved bits.
module fcd_chk #(
    parameter int CTL_W = 32,
    parameter int CNT_W = 25
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             cmd_start,
    input logic             cmd_stop,
    input logic             lp_exit,
    input logic [CTL_W-1:0] reg_rdata,
    input logic             tick_o,
    input logic             clk_div_o,
    input logic [CNT_W-1:0] cnt
);

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[2:1] == 2'b00);

    // R2
    write_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !cmd_start && !cmd_stop) |=> (reg_rdata[0] == $past(reg_rdata[0])));

    // R3
    start_sets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !cmd_stop) |=> reg_rdata[0]);

    // R4
    stop_quiets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (!reg_rdata[0] && !tick_o));

    // R4
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[0] && !cmd_start) |=> ##1 !clk_div_o);

    // R9
    wake_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_exit && reg_rdata[0] && !cmd_stop) |=> (cnt == '0 && reg_rdata[0]));

endmodule

bind frac_clk_div fcd_chk #(.CTL_W(CTL_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .lp_exit   (lp_exit),
    .reg_rdata (reg_rdata),
    .tick_o    (tick_o),
    .clk_div_o (clk_div_o),
    .cnt       (cnt_w)
);

// File: tb/sim_frac_clk_div.sv
`timescale 1ns/1ps
module sim_frac_clk_div;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        cmd_start = 1'b0;
    logic        cmd_stop = 1'b0;
    logic        lp_exit = 1'b0;
    logic [31:0] reg_rdata;
    logic        tick_o;
    logic        clk_div_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    frac_clk_div u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .lp_exit   (lp_exit),
        .reg_rdata (reg_rdata),
        .tick_o    (tick_o),
        .clk_div_o (clk_div_o)
    );

    // Reference model state, built from the requirements
    int m_int = 0, m_frac = 0, m_iact = 0, m_cnt = 0, m_acc = 0, m_str = 0;
    bit m_run = 0, m_clk = 0;

    function automatic int m_limit();
        return m_iact + m_str;
    endfunction

    function automatic logic [31:0] m_word();
        return {m_int[23:0], m_frac[4:0], 2'b00, m_run};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model on the rising edge (R3, R4, R6, R7, R8, R9, R10)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_int <= 0; m_frac <= 0; m_iact <= 0; m_cnt <= 0;
            m_acc <= 0; m_str <= 0; m_run <= 0; m_clk <= 0;
        end else begin
            if (reg_wr) begin
                m_int  <= int'(reg_wdata[31:8]);
                m_frac <= int'(reg_wdata[7:3]);
            end
            if (cmd_stop)       m_run <= 0;
            else if (cmd_start) m_run <= 1;
            m_clk <= m_run && (m_cnt >= (m_limit() + 1) / 2);
            if (cmd_stop || (cmd_start && !m_run) || lp_exit) begin
                m_cnt <= 0; m_acc <= 0; m_str <= 0; m_iact <= m_int;
            end else if (m_run && m_cnt == m_limit()) begin
                m_cnt  <= 0;
                m_iact <= m_int;
                m_acc  <= (m_acc + m_frac) % 32;
                m_str  <= ((m_acc + m_frac) >= 32) ? 1 : 0;
            end else if (m_run) begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    // Compare outputs with the model away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(reg_rdata == m_word(), "R1 readback", int'(reg_rdata), int'(m_word()));
            chk(tick_o == (m_run && m_cnt == m_limit()), "R5 pulse", int'(tick_o),
                int'(m_run && m_cnt == m_limit()));
            chk(clk_div_o == m_clk, "R8 divided clock", int'(clk_div_o), int'(m_clk));
        end
    end

    task automatic clear_strobes();
        reg_wr = 0; cmd_start = 0; cmd_stop = 0; lp_exit = 0;
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            clear_strobes();
        end
    endtask

    // Count falling edges up to the next pulse; also count divided-clock highs
    task automatic next_tick(output int gap, output int hi);
        gap = 0; hi = 0;
        do begin
            @(negedge clk);
            clear_strobes();
            gap++;
            if (clk_div_o) hi++;
        end while (!tick_o && gap < 1000);
    endtask

    task automatic wr(int iv, int fv, bit b0);
        reg_wr = 1;
        reg_wdata = {iv[23:0], fv[4:0], 2'b11, b0};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        int g, h, sum;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(reg_rdata == 0, "R1 reset word", int'(reg_rdata), 0);
        chk(!tick_o && !clk_div_o, "R4 reset outputs", int'(tick_o), 0);

        // R1, R2: write with bit 0 set leaves running clear
        wr(4, 0, 1'b1); step(1);
        chk(reg_rdata == 32'h0000_0400, "R1 field store", int'(reg_rdata), 32'h400);
        chk(reg_rdata[0] == 1'b0, "R2 bit0 ignored", int'(reg_rdata[0]), 0);

        // R3: start, first pulse after N=5
        cmd_start = 1; next_tick(g, h);
        chk(g == 5, "R3 first period", g, 5);
        // R5: pulse lasts one cycle
        step(1);
        chk(tick_o == 0, "R5 single cycle", int'(tick_o), 0);
        next_tick(g, h);
        chk(g == 4, "R5 repeat period", g, 4);
        // R8: N=5 gives 3 high cycles of 5
        next_tick(g, h);
        chk(g == 5 && h == 3, "R8 odd duty", h, 3);
        wr(5, 0, 0); next_tick(g, h); next_tick(g, h);
        chk(g == 6 && h == 3, "R8 even duty", h, 3);

        // R10: start while running does not restart
        wr(4, 0, 0); next_tick(g, h); step(2);
        cmd_start = 1; next_tick(g, h);
        chk(g == 3, "R10 start ignored", g, 3);

        // R9: low-power exit restarts a period and keeps settings
        wr(6, 0, 0); next_tick(g, h); step(2);
        lp_exit = 1; next_tick(g, h);
        chk(g == 7, "R9 restart period", g, 7);
        chk(reg_rdata == 32'h0000_0601, "R9 settings kept", int'(reg_rdata), 32'h601);

        // R7: write mid-period does not truncate
        wr(9, 0, 0); next_tick(g, h); next_tick(g, h);
        chk(g == 10, "R7 old period", g, 10);
        step(3); wr(2, 0, 0); next_tick(g, h);
        chk(g == 7, "R7 not truncated", g, 7);
        next_tick(g, h);
        chk(g == 3, "R7 new period", g, 3);

        // R6: fraction 8/32 over 32 periods after the first
        wr(2, 8, 0); step(1); cmd_stop = 1; step(1);
        cmd_start = 1; next_tick(g, h);
        chk(g == 3, "R6 first period", g, 3);
        sum = 0;
        for (int k = 0; k < 32; k++) begin
            next_tick(g, h);
            sum += g;
            if (g != 3 && g != 4) chk(0, "R6 period range", g, 3);
        end
        chk(sum == 104, "R6 mean ratio", sum, 104);

        // R5: ratio 1 gives a pulse each cycle
        wr(0, 0, 0); step(1); cmd_stop = 1; step(1); cmd_start = 1; step(1);
        for (int k = 0; k < 6; k++) begin
            chk(tick_o == 1, "R5 ratio one", int'(tick_o), 1);
            step(1);
        end

        // R4: stop, and stop with start together
        cmd_stop = 1; step(1);
        chk(reg_rdata[0] == 0 && tick_o == 0, "R4 stopped", int'(reg_rdata[0]), 0);
        cmd_stop = 1; cmd_start = 1; step(2);
        chk(reg_rdata[0] == 0 && clk_div_o == 0, "R4 stop wins", int'(reg_rdata[0]), 0);

        // Random mix, checked against the model each cycle
        for (int c = 0; c < 6000; c++) begin
            if ($urandom_range(99) < 5)
                wr(int'($urandom_range(7)), int'($urandom_range(31)), 1'($urandom_range(1)));
            if ($urandom_range(99) < 3) cmd_start = 1;
            if ($urandom_range(199) < 1) cmd_stop = 1;
            if ($urandom_range(99) < 1) lp_exit = 1;
            step(1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule